// File: doc/BRIEF.md
# Gate driver fault and pulse controller

This block is the digital control core of a single-channel power-switch gate driver. It receives a logic switching command, a digital flag from an external desaturation comparator and a flag that says the driver supplies are valid. From these it drives four outputs: an enable for the turn-on (source) stage, an enable for the hard turn-off (sink) stage, an enable for a slow soft-shutdown path, and an active-low fault line. The fault line is modelled as an open-drain pin: 0 means pulled low, 1 means released.

Once the supplies are valid, the block stays inert for a start-up delay. After that, every accepted on-command is passed to the turn-on stage one clock later. On-commands shorter than a minimum width are stretched to that width, and longer ones keep their length. The desaturation flag matters only while the switch is on and after a blanking window. When it trips, the block turns the switch off through the soft-shutdown path and then holds a lockout. Throughout that time it pulls the fault line low and ignores commands. Afterwards it waits for the command to go low before it will accept a new one. All time constants are parameters counted in clock cycles.

Top module: `gate_fault_ctl`

## Requirements
- R1: After reset, or after `supply_ok` returns, `cmd_in` is ignored until `supply_ok` has been high at START_CYC consecutive rising edges. With `cmd_in` held high, `gate_on_en` rises after rising edge START_CYC+1.
- R2: While `supply_ok` is low, the outputs are `gate_on_en`=0, `gate_off_en`=1, `soft_off_en`=0, `fault_n`=1 in the same cycle. Any running sequence is abandoned and the start-up delay of R1 starts again.
- R3: `gate_on_en` and `gate_off_en` are never high together. In the idle off state, `gate_off_en`=1.
- R4: When `cmd_in` is sampled high at an edge while the block is idle, `gate_on_en` goes high after that edge. If the command lasts fewer than MINON_CYC cycles, `gate_on_en` stays high for exactly MINON_CYC cycles.
- R5: An on-command of N ≥ MINON_CYC cycles gives a `gate_on_en` pulse of exactly N cycles, delayed by one cycle.
- R6: `desat_in` has no effect while the switch is off. With `desat_in` high from the moment of turn-on, `gate_on_en` stays high for exactly BLANK_CYC cycles before the trip.
- R7: On a trip, from the next cycle and for SOFT_CYC cycles, the outputs are `soft_off_en`=1, `gate_on_en`=0, `gate_off_en`=0 and `fault_n`=0.
- R8: A lockout of LOCK_CYC cycles follows the soft-off, with `gate_off_en`=1 and `fault_n`=0. `cmd_in` is ignored during both the soft-off and the lockout.
- R9: After the lockout, `fault_n`=1. If `cmd_in` is still high, `gate_on_en` stays low until `cmd_in` has been sampled low once. A later on-command then works normally.
- R10: While `rst` is high at a rising edge, the outputs become `gate_on_en`=0, `gate_off_en`=1, `soft_off_en`=0, `fault_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_in | input | 1 | Switch command, 1 = on |
| desat_in | input | 1 | Desaturation comparator flag, 1 = collector voltage above threshold |
| supply_ok | input | 1 | All driver supplies valid |
| gate_on_en | output | 1 | Turn-on (source) stage enable |
| gate_off_en | output | 1 | Hard turn-off (sink) stage enable |
| soft_off_en | output | 1 | Soft-shutdown path enable |
| fault_n | output | 1 | Open-drain fault line, 0 = pulled low |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that the timing parameters are at least 1, so that every counter compare refers to a reachable value. The bench changes inputs only at falling edges and keeps START_CYC, BLANK_CYC, MINON_CYC, SOFT_CYC and LOCK_CYC at small non-zero values. It drops `supply_ok` only while the switch is on, and it toggles `cmd_in` inside the lockout to show that the block does not react.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONDUCT,
        ST_SOFTOFF,
        ST_LOCKOUT,
        ST_REARM
    } gdc_state_e;

    typedef struct packed {
        logic src_en;
        logic snk_en;
        logic slow_en;
        logic flt_n;
    } gdc_drive_s;

    localparam gdc_drive_s DRIVE_SAFE = '{src_en: 1'b0, snk_en: 1'b1, slow_en: 1'b0, flt_n: 1'b1};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic gdc_drive_s drive_of(input gdc_state_e st);
        gdc_drive_s d;
        d = DRIVE_SAFE;
        case (st)
            ST_CONDUCT: d = '{src_en: 1'b1, snk_en: 1'b0, slow_en: 1'b0, flt_n: 1'b1};
            ST_SOFTOFF: d = '{src_en: 1'b0, snk_en: 1'b0, slow_en: 1'b1, flt_n: 1'b0};
            ST_LOCKOUT: d = '{src_en: 1'b0, snk_en: 1'b1, slow_en: 1'b0, flt_n: 1'b0};
            default:    d = DRIVE_SAFE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gdc_startup.sv
module gdc_startup #(
    parameter int unsigned START_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic ready
);
    localparam int unsigned CW = $clog2(START_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(START_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          rdy_q;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else if (!rdy_q) begin
            if (cnt_q == LAST) rdy_q <= 1'b1;
            else               cnt_q <= cnt_q + CW'(1);
        end
    end

    assign ready = rdy_q;

    // R1
    ready_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(supply_ok));

endmodule

// File: rtl/gdc_seq.sv
module gdc_seq
    import gdc_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 4,
    parameter int unsigned MINON_CYC = 6,
    parameter int unsigned SOFT_CYC  = 5,
    parameter int unsigned LOCK_CYC  = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ready,
    input  logic       supply_ok,
    input  logic       cmd,
    input  logic       desat,
    output gdc_state_e state
);
    localparam int unsigned CMAX = max2(max2(BLANK_CYC, MINON_CYC), max2(SOFT_CYC, LOCK_CYC));
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] K_BLANK = CW'(BLANK_CYC - 1);
    localparam logic [CW-1:0] K_MINON = CW'(MINON_CYC - 1);
    localparam logic [CW-1:0] K_SOFT  = CW'(SOFT_CYC - 1);
    localparam logic [CW-1:0] K_LOCK  = CW'(LOCK_CYC - 1);
    localparam logic [CW-1:0] K_TOP   = CW'(CMAX);

    gdc_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!ready || !supply_ok) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd) begin
                        st_d  = ST_CONDUCT;
                        cnt_d = '0;
                    end
                end
                ST_CONDUCT: begin
                    if (desat && cnt_q >= K_BLANK) begin
                        st_d  = ST_SOFTOFF;
                        cnt_d = '0;
                    end else if (!cmd && cnt_q >= K_MINON) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else if (cnt_q != K_TOP) begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_SOFTOFF: begin
                    if (cnt_q == K_SOFT) begin
                        st_d  = ST_LOCKOUT;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_LOCKOUT: begin
                    if (cnt_q == K_LOCK) begin
                        st_d  = ST_REARM;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_REARM: begin
                    if (!cmd) st_d = ST_IDLE;
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;

    // R8
    fault_no_on_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SOFTOFF || st_q == ST_LOCKOUT) |=> (st_q != ST_CONDUCT));

    // R9
    rearm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REARM && cmd) |=> (st_q == ST_REARM || st_q == ST_IDLE) && st_q != ST_CONDUCT);

    // R7
    soft_path_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SOFTOFF && ready && supply_ok) |=> (st_q == ST_SOFTOFF || st_q == ST_LOCKOUT));

    // R6
    idle_desat_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_CONDUCT));

endmodule

// File: rtl/gdc_drive.sv
module gdc_drive
    import gdc_pkg::*;
(
    input  gdc_state_e state,
    input  logic       supply_ok,
    output gdc_drive_s drv
);
    always_comb begin
        if (supply_ok) drv = drive_of(state);
        else           drv = DRIVE_SAFE;
    end
endmodule

// File: rtl/gate_fault_ctl.sv
module gate_fault_ctl
    import gdc_pkg::*;
#(
    parameter int unsigned START_CYC = 8,
    parameter int unsigned BLANK_CYC = 4,
    parameter int unsigned MINON_CYC = 6,
    parameter int unsigned SOFT_CYC  = 5,
    parameter int unsigned LOCK_CYC  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_in,
    input  logic desat_in,
    input  logic supply_ok,
    output logic gate_on_en,
    output logic gate_off_en,
    output logic soft_off_en,
    output logic fault_n
);
    logic       ready;
    gdc_state_e state;
    gdc_drive_s drv;

    gdc_startup #(.START_CYC(START_CYC)) u_startup (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .ready     (ready)
    );

    gdc_seq #(
        .BLANK_CYC (BLANK_CYC),
        .MINON_CYC (MINON_CYC),
        .SOFT_CYC  (SOFT_CYC),
        .LOCK_CYC  (LOCK_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .supply_ok (supply_ok),
        .cmd       (cmd_in),
        .desat     (desat_in),
        .state     (state)
    );

    gdc_drive u_drive (
        .state     (state),
        .supply_ok (supply_ok),
        .drv       (drv)
    );

    assign gate_on_en  = drv.src_en;
    assign gate_off_en = drv.snk_en;
    assign soft_off_en = drv.slow_en;
    assign fault_n     = drv.flt_n;

    // R3
    gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_on_en && gate_off_en));

    // R7
    soft_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        soft_off_en |-> (!gate_on_en && !gate_off_en && !fault_n));

    // R1
    startup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !gate_on_en);

    // R2
    supply_safe_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> (gate_off_en && !gate_on_en && !soft_off_en && fault_n));

    // R4
    on_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on_en) |-> $past(cmd_in));

endmodule

// File: tb/gate_fault_ctl_tb.sv
module gate_fault_ctl_tb;
    localparam int unsigned P_START = 8;
    localparam int unsigned P_BLANK = 4;
    localparam int unsigned P_MINON = 6;
    localparam int unsigned P_SOFT  = 5;
    localparam int unsigned P_LOCK  = 10;

    // stimulus width, expected gate_on_en width
    localparam int PULSE_TAB [6][2] = '{'{1, 6}, '{2, 6}, '{5, 6}, '{6, 6}, '{7, 7}, '{11, 11}};

    logic clk = 1'b0;
    logic rst, cmd_in, desat_in, supply_ok;
    logic gate_on_en, gate_off_en, soft_off_en, fault_n;
    int   n_chk = 0;
    int   n_err = 0;

    always #10 clk = ~clk;

    gate_fault_ctl #(
        .START_CYC (P_START),
        .BLANK_CYC (P_BLANK),
        .MINON_CYC (P_MINON),
        .SOFT_CYC  (P_SOFT),
        .LOCK_CYC  (P_LOCK)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_in      (cmd_in),
        .desat_in    (desat_in),
        .supply_ok   (supply_ok),
        .gate_on_en  (gate_on_en),
        .gate_off_en (gate_off_en),
        .soft_off_en (soft_off_en),
        .fault_n     (fault_n)
    );

    task automatic chk_bit(input string req, input string name, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, name, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string name, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, name, act, exp, $time);
        end
    endtask

    task automatic expect_out(input string req, input logic e_on, input logic e_off,
                              input logic e_soft, input logic e_fn);
        chk_bit(req, "gate_on_en", gate_on_en, e_on);
        chk_bit(req, "gate_off_en", gate_off_en, e_off);
        chk_bit(req, "soft_off_en", soft_off_en, e_soft);
        chk_bit(req, "fault_n", fault_n, e_fn);
        chk_bit("R3", "on_and_off_both", gate_on_en & gate_off_en, 1'b0);
    endtask

    task automatic run_pulse(input string req, input int width, output int measured);
        int cnt;
        logic first;
        cnt = 0;
        first = 1'b0;
        @(negedge clk);
        cmd_in = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 1) first = gate_on_en;
            if (gate_on_en) cnt++;
            chk_bit("R3", "on_and_off_both", gate_on_en & gate_off_en, 1'b0);
            if (i == width) cmd_in = 1'b0;
        end
        chk_bit(req, "onset_after_one_edge", first, 1'b1);
        measured = cnt;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog all-requirements act=timeout exp=completion");
        finish_run();
    end

    initial begin
        int w;
        rst = 1'b1;
        cmd_in = 1'b0;
        desat_in = 1'b0;
        supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        expect_out("R10", 1'b0, 1'b1, 1'b0, 1'b1);

        // R1: start-up delay with command held high
        rst = 1'b0;
        cmd_in = 1'b1;
        for (int i = 1; i <= int'(P_START); i++) begin
            @(negedge clk);
            chk_bit("R1", "gate_on_en_during_startup", gate_on_en, 1'b0);
        end
        @(negedge clk);
        chk_bit("R1", "gate_on_en_after_startup", gate_on_en, 1'b1);
        cmd_in = 1'b0;
        repeat (10) @(negedge clk);
        // R3: idle off state
        expect_out("R3", 1'b0, 1'b1, 1'b0, 1'b1);

        // R4 R5: pulse width table
        for (int k = 0; k < 6; k++) begin
            run_pulse((PULSE_TAB[k][0] < int'(P_MINON)) ? "R4" : "R5", PULSE_TAB[k][0], w);
            chk_int((PULSE_TAB[k][0] < int'(P_MINON)) ? "R4" : "R5", "pulse_width", w, PULSE_TAB[k][1]);
        end

        // R6: desat while off has no effect
        desat_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            expect_out("R6", 1'b0, 1'b1, 1'b0, 1'b1);
        end

        // R6 R7 R8 R9: trip with desat high from turn-on
        cmd_in = 1'b1;
        for (int i = 1; i <= 25; i++) begin
            @(negedge clk);
            if (i <= int'(P_BLANK))
                expect_out("R6", 1'b1, 1'b0, 1'b0, 1'b1);
            else if (i <= int'(P_BLANK + P_SOFT))
                expect_out("R7", 1'b0, 1'b0, 1'b1, 1'b0);
            else if (i <= int'(P_BLANK + P_SOFT + P_LOCK))
                expect_out("R8", 1'b0, 1'b1, 1'b0, 1'b0);
            else
                expect_out("R9", 1'b0, 1'b1, 1'b0, 1'b1);
            if (i == 6)  desat_in = 1'b0;
            if (i == 12) cmd_in = 1'b0;
            if (i == 14) cmd_in = 1'b1;
        end
        cmd_in = 1'b0;
        @(negedge clk);
        expect_out("R9", 1'b0, 1'b1, 1'b0, 1'b1);
        run_pulse("R9", 8, w);
        chk_int("R9", "pulse_width_after_rearm", w, 8);

        // R2: supply loss while on
        @(negedge clk);
        cmd_in = 1'b1;
        @(negedge clk);
        chk_bit("R2", "gate_on_en_before_drop", gate_on_en, 1'b1);
        supply_ok = 1'b0;
        #1;
        expect_out("R2", 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        supply_ok = 1'b1;
        for (int i = 1; i <= int'(P_START); i++) begin
            @(negedge clk);
            chk_bit("R2", "gate_on_en_startup_restart", gate_on_en, 1'b0);
        end
        @(negedge clk);
        chk_bit("R2", "gate_on_en_after_restart", gate_on_en, 1'b1);
        cmd_in = 1'b0;
        repeat (10) @(negedge clk);
        expect_out("R3", 1'b0, 1'b1, 1'b0, 1'b1);

        finish_run();
    end

endmodule